// File: doc/BRIEF.md
# Parallel Host Control Register Port

This block gives a host processor indirect access to a small bank of control registers over an 8-bit bidirectional bus. There is one address-select input. With it low, an access reaches an internal register pointer. With it high, the access reaches the register that the pointer currently selects. After each data access the pointer steps forward by one. It stops at the last implemented address, so a host can stream a run of consecutive registers after a single pointer load.

The bank holds several kinds of register:
- four read-only identification bytes;
- writable control registers with fixed reset values;
- a field-status register whose middle bits show a live field number;
- a general-purpose port register that combines host-written output bits, two mirrored input pins and two live timing flags.

An access begins when chip select falls and takes effect when chip select rises. Bus values are sampled on the system clock while chip select is low. A write and the pointer step both take place on the first clock edge after chip select returns high. Read data is driven onto the bus for as long as chip select is low with the read/write line high.

Top module: `hostRegPort`

## Requirements
- R1: An access with addrSel = 0 and rdWrN = 0 loads the bus byte into the pointer. A read with addrSel = 0 returns the pointer. The pointer is 00h after reset.
- R2: While csN is high, changes on rdWrN, addrSel and the bus alter neither the pointer nor any register.
- R3: A read with addrSel = 1 returns the register at the pointer. A write with addrSel = 1 updates only that register's writable bits.
- R4: Each access with addrSel = 1 advances the pointer by one if it is below 22h. At 22h or above, the pointer keeps its value.
- R5: Addresses 00h, 01h and 02h read 97h, 24h and 90h. Address 03h reads the REV_ID parameter (default 01h). Writes to these four addresses have no effect.
- R6: After reset, 04h reads 00h, 05h reads 01h, 0Fh reads F2h, 20h and 21h read 80h, and every other writable register reads 00h.
- R7: Bits 7 and 6 of register 0Eh read gpIn[1] and gpIn[0] at the time of the read. Writes to these two bits have no effect.
- R8: Bits 5..2 of register 0Eh are read/write. gpOut[3:0] equals those bits while gpOutEn is 1 and is 0000b while gpOutEn is 0.
- R9: Bit 1 of register 0Eh reads burstFlag and bit 0 reads compSyncN, both live.
- R10: Bits 5..3 of register 06h read fieldNum (0 = field 1, 7 = field 8) and ignore writes. Bits 7..6 and 2..0 are read/write.
- R11: Addresses above 22h read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; a rising edge completes the access |
| rdWrN | input | 1 | 1 = read, 0 = write |
| addrSel | input | 1 | 0 = pointer, 1 = data at the pointer |
| dataBus | inout | 8 | Bidirectional host data bus |
| gpIn | input | 2 | Mirrored input pins (bit 1 shows in register bit 7) |
| gpOutEn | input | 1 | Enables the general-purpose output pins |
| gpOut | output | 4 | General-purpose outputs from register 0Eh bits 5..2 |
| burstFlag | input | 1 | Live burst-gate status |
| compSyncN | input | 1 | Live composite sync, low during sync tips |
| fieldNum | input | 3 | Live field number |

## Verification
The bench drives the pointer into saturation from just below 22h and from loads above it. A design with a wrong limit would wrap or keep counting, and later reads would land on the wrong register. It writes all-ones patterns to the identification bytes, the read-only bits of 06h and 0Eh, and addresses above 22h. A design with a missing write mask would then return the written bits instead of live or fixed values. It also changes the host lines with chip select high, and it reads the live bits under random status inputs. A design that ignored chip select, or latched the status inputs, would then show a moved pointer or stale flags.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  localparam int DATA_W    = 8;
  localparam int PTR_LIMIT = 'h22;
  localparam int NUM_REGS  = PTR_LIMIT + 1;
  localparam int ID_COUNT  = 4;
  localparam int FIELD_REG = 'h06;
  localparam int GPIO_REG  = 'h0E;

  typedef struct packed {
    logic ptrWr;
    logic regWr;
    logic advance;
  } hrpStrobe_t;

  function automatic logic [DATA_W-1:0] resetValue(int addr);
    case (addr)
      'h05:       return 8'h01;
      'h0F:       return 8'hF2;
      'h20, 'h21: return 8'h80;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] writeMask(int addr);
    if (addr < ID_COUNT)   return 8'h00;
    if (addr == FIELD_REG) return 8'hC7;
    if (addr == GPIO_REG)  return 8'h3C;
    if (addr > PTR_LIMIT)  return 8'h00;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/hrpControl.sv
module hrpControl
  import hrp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdWrN,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] busIn,
  output hrpStrobe_t        stb,
  output logic [DATA_W-1:0] wrData
);

  logic csNq;
  logic rdWrNq;
  logic addrSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csNq     <= 1'b1;
      rdWrNq   <= 1'b1;
      addrSelQ <= 1'b0;
      wrData   <= '0;
    end else begin
      csNq <= csN;
      if (!csN) begin
        rdWrNq   <= rdWrN;
        addrSelQ <= addrSel;
        wrData   <= busIn;
      end
    end
  end

  logic accessEnd;
  assign accessEnd = csN && !csNq;

  always_comb begin
    stb.ptrWr   = accessEnd && !rdWrNq && !addrSelQ;
    stb.regWr   = accessEnd && !rdWrNq && addrSelQ;
    stb.advance = accessEnd && addrSelQ;
  end

endmodule

// File: rtl/hrpDatapath.sv
module hrpDatapath
  import hrp_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  hrpStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              addrSel,
  input  logic [1:0]        gpIn,
  input  logic              burstFlag,
  input  logic              compSyncN,
  input  logic [2:0]        fieldNum,
  input  logic              gpOutEn,
  output logic [DATA_W-1:0] ptr,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        gpOut
);

  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(PTR_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             ptr <= '0;
    else if (stb.ptrWr)                    ptr <= wrData;
    else if (stb.advance && ptr < LIMIT)   ptr <= ptr + 1'b1;
  end

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = writeMask(i);
    localparam logic [DATA_W-1:0] INIT = resetValue(i);
    if (MASK == '0) begin : g_fixed
      assign regs[i] = INIT;
    end else begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= INIT;
        else if (stb.regWr && ptr == DATA_W'(i))
          q <= (q & ~MASK) | (wrData & MASK);
      end
      assign regs[i] = q;
    end
  end

  logic [DATA_W-1:0] regRead;

  always_comb begin
    regRead = 8'h00;
    if (ptr <= LIMIT) regRead = regs[ptr[5:0]];
    case (ptr)
      8'h00: regRead = 8'h97;
      8'h01: regRead = 8'h24;
      8'h02: regRead = 8'h90;
      8'h03: regRead = REV_ID;
      8'h06: regRead = {regs[FIELD_REG][7:6], fieldNum, regs[FIELD_REG][2:0]};
      8'h0E: regRead = {gpIn, regs[GPIO_REG][5:2], burstFlag, compSyncN};
      default: ;
    endcase
  end

  assign rdData = addrSel ? regRead : ptr;
  assign gpOut  = gpOutEn ? regs[GPIO_REG][5:2] : 4'b0000;

endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hrp_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdWrN,
  input  logic       addrSel,
  inout  wire  [7:0] dataBus,
  input  logic [1:0] gpIn,
  input  logic       gpOutEn,
  output logic [3:0] gpOut,
  input  logic       burstFlag,
  input  logic       compSyncN,
  input  logic [2:0] fieldNum
);

  hrpStrobe_t  stb;
  logic [7:0]  wrData;
  logic [7:0]  ptr;
  logic [7:0]  rdData;

  hrpControl i_control (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .addrSel(addrSel),
    .busIn(dataBus), .stb(stb), .wrData(wrData)
  );

  hrpDatapath #(.REV_ID(REV_ID)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .addrSel(addrSel),
    .gpIn(gpIn), .burstFlag(burstFlag), .compSyncN(compSyncN),
    .fieldNum(fieldNum), .gpOutEn(gpOutEn), .ptr(ptr), .rdData(rdData),
    .gpOut(gpOut)
  );

  assign dataBus = (!csN && rdWrN) ? rdData : 8'bz;

endmodule

// File: rtl/hrpChecker.sv
module hrpChecker
  import hrp_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       rdWrN,
  input logic       addrSel,
  input logic [1:0] gpIn,
  input logic       burstFlag,
  input logic       compSyncN,
  input logic [7:0] ptr,
  input logic [7:0] rdData,
  input hrpStrobe_t stb
);

  // R2: two high samples of chip select leave the pointer unchanged
  a_r2_idle_ptr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |=> $stable(ptr));

  // R4: the pointer steps by one below the limit
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.ptrWr && ptr < 8'h22) |=> ptr == $past(ptr) + 8'h01);

  // R4: the pointer holds at the limit
  a_r4_ptr_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == 8'h22 && !stb.ptrWr) |=> ptr == 8'h22);

  // R5: the first identification byte is fixed
  a_r5_id_byte: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rdWrN && addrSel && ptr == 8'h00) |-> rdData == 8'h97);

  // R7 and R9: live bits of the port register follow the pins
  a_r7_gpin_live: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rdWrN && addrSel && ptr == 8'h0E) |-> rdData[7:6] == gpIn);

  a_r9_flags_live: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rdWrN && addrSel && ptr == 8'h0E) |->
      rdData[1:0] == {burstFlag, compSyncN});

  // R1: a pointer read returns the pointer
  a_r1_ptr_read: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && rdWrN && !addrSel) |-> rdData == ptr);

endmodule

bind hostRegPort hrpChecker i_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .addrSel(addrSel),
  .gpIn(gpIn), .burstFlag(burstFlag), .compSyncN(compSyncN),
  .ptr(ptr), .rdData(rdData), .stb(stb)
);

// File: tb/test_hostRegPort.sv
`timescale 1ns/1ps
module test_hostRegPort;

  localparam logic [7:0] REV = 8'h01;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       rdWrN = 1'b1;
  logic       addrSel = 1'b0;
  logic [7:0] tbDrive = 8'h00;
  logic       tbEn = 1'b0;
  logic [1:0] gpIn = 2'b00;
  logic       gpOutEn = 1'b0;
  logic [3:0] gpOut;
  logic       burstFlag = 1'b0;
  logic       compSyncN = 1'b1;
  logic [2:0] fieldNum = 3'd0;
  wire  [7:0] dataBus;

  assign dataBus = tbEn ? tbDrive : 8'bz;

  always #5 clk = ~clk;

  hostRegPort #(.REV_ID(REV)) i_hostRegPort (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWrN(rdWrN), .addrSel(addrSel),
    .dataBus(dataBus), .gpIn(gpIn), .gpOutEn(gpOutEn), .gpOut(gpOut),
    .burstFlag(burstFlag), .compSyncN(compSyncN), .fieldNum(fieldNum)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] mdl [0:34];
  logic [7:0] mPtr;

  function automatic logic [7:0] resetOf(int a);
    case (a)
      'h05: return 8'h01;
      'h0F: return 8'hF2;
      'h20, 'h21: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] maskOf(int a);
    if (a < 4) return 8'h00;
    if (a == 'h06) return 8'hC7;
    if (a == 'h0E) return 8'h3C;
    if (a > 'h22) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return 8'h97;
      8'h01: return 8'h24;
      8'h02: return 8'h90;
      8'h03: return REV;
      8'h06: return {mdl[6][7:6], fieldNum, mdl[6][2:0]};
      8'h0E: return {gpIn, mdl[14][5:2], burstFlag, compSyncN};
      default: return (a > 8'h22) ? 8'h00 : mdl[a];
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic stepPtr();
    if (mPtr < 8'h22) mPtr = mPtr + 8'h01;
  endtask

  task automatic hostWrite(logic sel, logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; rdWrN = 1'b0; addrSel = sel; tbDrive = d; tbEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
    tbEn = 1'b0; rdWrN = 1'b1;
    @(negedge clk);
    if (!sel) mPtr = d;
    else begin
      if (mPtr <= 8'h22)
        mdl[mPtr] = (mdl[mPtr] & ~maskOf(int'(mPtr))) | (d & maskOf(int'(mPtr)));
      stepPtr();
    end
  endtask

  task automatic hostRead(logic sel, output logic [7:0] v);
    @(negedge clk);
    csN = 1'b0; rdWrN = 1'b1; addrSel = sel;
    @(negedge clk);
    v = dataBus;
    csN = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readData(string tag);
    logic [7:0] v;
    logic [7:0] e;
    e = expRead(mPtr);
    hostRead(1'b1, v);
    chk(tag, v, e);
    stepPtr();
  endtask

  task automatic readPtr(string tag);
    logic [7:0] v;
    hostRead(1'b0, v);
    chk(tag, v, mPtr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED_2490));
    for (int a = 0; a < 35; a++) mdl[a] = resetOf(a) & maskOf(a);
    mPtr = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: pointer after reset
    readPtr("R1 reset pointer");
    // R5: identification bytes, then R6 defaults across the bank
    for (int a = 0; a < 35; a++) readData((a < 4) ? "R5 id byte" : "R6 reset value");
    readPtr("R4 saturated pointer");

    // R5: writes to identification bytes are ignored
    hostWrite(1'b0, 8'h00);
    for (int a = 0; a < 4; a++) hostWrite(1'b1, 8'hFF);
    hostWrite(1'b0, 8'h00);
    for (int a = 0; a < 4; a++) readData("R5 id after write");

    // R10: read-only field bits
    fieldNum = 3'd5;
    hostWrite(1'b0, 8'h06);
    hostWrite(1'b1, 8'hFF);
    hostWrite(1'b0, 8'h06);
    readData("R10 field bits");
    fieldNum = 3'd7;
    hostWrite(1'b0, 8'h06);
    readData("R10 field live");

    // R7 R8 R9: port register
    hostWrite(1'b0, 8'h0E);
    hostWrite(1'b1, 8'hFF);
    gpIn = 2'b10; burstFlag = 1'b1; compSyncN = 1'b0; gpOutEn = 1'b1;
    hostWrite(1'b0, 8'h0E);
    readData("R7 R9 port register");
    chk("R8 gpOut enabled", {4'h0, gpOut}, 8'h0F);
    gpOutEn = 1'b0;
    #1 chk("R8 gpOut disabled", {4'h0, gpOut}, 8'h00);

    // R4: saturation from below and a load above the limit
    hostWrite(1'b0, 8'h20);
    for (int k = 0; k < 5; k++) readData("R4 walk to limit");
    readPtr("R4 held at limit");
    hostWrite(1'b0, 8'h30);
    hostWrite(1'b1, 8'hAA);
    readPtr("R4 above limit holds");
    readData("R11 above limit reads zero");

    // R2: host line activity with chip select high
    hostWrite(1'b0, 8'h10);
    @(negedge clk);
    rdWrN = 1'b0; addrSel = 1'b1; tbDrive = 8'h5A; tbEn = 1'b1;
    repeat (3) @(negedge clk);
    addrSel = 1'b0;
    repeat (2) @(negedge clk);
    tbEn = 1'b0; rdWrN = 1'b1;
    readPtr("R2 pointer unchanged");
    readData("R2 register unchanged");

    // R3: random traffic against the model
    for (int n = 0; n < 400; n++) begin
      int op;
      gpIn      = 2'($urandom);
      burstFlag = 1'($urandom);
      compSyncN = 1'($urandom);
      fieldNum  = 3'($urandom);
      gpOutEn   = 1'($urandom);
      op = int'($urandom % 5);
      case (op)
        0: hostWrite(1'b0, 8'($urandom % 'h30));
        1, 2: hostWrite(1'b1, 8'($urandom));
        3: readData("R3 random read");
        default: readPtr("R1 random pointer read");
      endcase
      #1 chk("R8 gpOut random", {4'h0, gpOut}, gpOutEn ? {4'h0, mdl[14][5:2]} : 8'h00);
    end

    summary();
  end

endmodule